// File: doc/BRIEF.md
# SDRAM Burst Column Address Generator

This block produces the column address for every beat of an SDRAM read or write burst. A command path loads it with the starting column taken from the READ or WRITE command, together with a burst length code and a sequence type. After that the block presents one column per beat. It moves to the next beat on each clock where the advance input is high.

Fixed-length bursts stay inside the block of columns that is aligned to the burst length. They count either sequentially or in interleaved order, and they flag their final beat. A full-page burst walks through all 256 columns of the page and wraps around. It never ends by itself and stops only when it is terminated or reloaded. A load restarts the burst from a new column on any cycle. The terminate input ends a burst early.

Top module: `burst_col_gen`

## Requirements
- R1: After reset, colValid and lastBeat are both 0.
- R2: When load is high at a clock edge, the next cycle shows col equal to startCol, colValid equal to 1 and beat index 0. This holds even if a burst was running, and load takes priority over terminate in the same cycle.
- R3: While colValid is 1, each clock with advance high moves the burst one beat forward. Beats are counted from 0. A clock with advance low leaves col unchanged.
- R4: With lenCode 1, 2 or 3 the length is 2^lenCode. With interleave 0, the low lenCode bits of col equal (start + beat) mod length and the upper bits keep the start value.
- R5: With lenCode 1, 2 or 3 and interleave 1, the low lenCode bits of col equal the start bits XOR the beat index. The upper bits keep the start value.
- R6: lenCode 0 gives a burst of exactly one beat at startCol, and lastBeat is high on that beat. One advance ends the burst, so colValid becomes 0 on the next cycle.
- R7: In a fixed-length burst, lastBeat is high only on beat length−1. An advance on that beat drops colValid on the next cycle.
- R8: lenCode 4 to 7 selects full page. In this mode col equals (start + beat) mod 256, interleave has no effect, lastBeat is never high, and the burst keeps running past 256 beats.
- R9: When terminate is high without load, colValid becomes 0 on the next cycle, for both fixed-length and full-page bursts.
- R10: While colValid is 0, advance and terminate have no effect. colValid stays 0 until the next load.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rstN | input | 1 | Asynchronous reset, active low |
| load | input | 1 | Start a burst at startCol |
| startCol | input | 8 | Starting column of the burst |
| lenCode | input | 3 | Burst length code: 0 to 3 give 2^code beats, 4 to 7 give full page |
| interleave | input | 1 | 1 = interleaved order, 0 = sequential order |
| advance | input | 1 | Move to the next beat |
| terminate | input | 1 | End the current burst |
| col | output | 8 | Column address of the current beat |
| colValid | output | 1 | A burst beat is being presented |
| lastBeat | output | 1 | Current beat is the final beat of a fixed-length burst |

## Verification
The bench uses start columns whose low bits are not zero, so that wrapping must happen inside the aligned block. A design that carried into the upper bits would leave the block, and a design that XORed when it should add (or the reverse) would give a different beat order. A full-page burst is driven for more than 256 beats with interleave high. A design that capped full page at a fixed length, raised lastBeat, or applied interleaving in that mode would show a wrong column or an early end. Other cases cover a one-beat burst, gaps in advance, a reload in the middle of a burst, load and terminate arriving together, and stray advance or terminate pulses while idle. Wrong command priority or a stale beat count would show up in these as a wrong restart column or a false valid.

// File: rtl/bcg_pkg.sv
package bcg_pkg;
  typedef struct packed {
    logic loadEn;
    logic stepEn;
    logic stopEn;
  } bcg_strobe_t;
endpackage

// File: rtl/bcg_ctrl.sv
module bcg_ctrl
  import bcg_pkg::*;
(
  input  logic        clk,
  input  logic        rstN,
  input  logic        load,
  input  logic        advance,
  input  logic        terminate,
  input  logic        atLast,
  output bcg_strobe_t strb,
  output logic        active
);

  always_comb begin
    strb.loadEn = load;
    strb.stopEn = !load && active && (terminate || (advance && atLast));
    strb.stepEn = !load && active && !terminate && advance && !atLast;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)            active <= 1'b0;
    else if (strb.loadEn) active <= 1'b1;
    else if (strb.stopEn) active <= 1'b0;
  end

  assert_load_starts_R2: assert property (@(posedge clk) disable iff (!rstN)
    load |=> active);
  assert_term_stops_R9: assert property (@(posedge clk) disable iff (!rstN)
    (terminate && !load) |=> !active);
  assert_last_ends_R7: assert property (@(posedge clk) disable iff (!rstN)
    (active && advance && atLast && !load) |=> !active);
  assert_idle_holds_R10: assert property (@(posedge clk) disable iff (!rstN)
    (!active && !load) |=> !active);

endmodule

// File: rtl/bcg_dp.sv
module bcg_dp
  import bcg_pkg::*;
#(
  parameter int COL_W       = 8,
  parameter int CODE_W      = 3,
  parameter int MAX_LEN_LOG = 3
) (
  input  logic              clk,
  input  logic              rstN,
  input  bcg_strobe_t       strb,
  input  logic [COL_W-1:0]  startCol,
  input  logic [CODE_W-1:0] lenCode,
  input  logic              interleave,
  output logic [COL_W-1:0]  col,
  output logic              atLast,
  output logic              fullMode
);

  logic [COL_W-1:0]  baseCol;
  logic [COL_W-1:0]  beatCnt;
  logic [CODE_W-1:0] codeQ;
  logic              ilQ;
  logic [COL_W-1:0]  mask;
  logic [COL_W-1:0]  sumCol;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      baseCol <= '0;
      beatCnt <= '0;
      codeQ   <= '0;
      ilQ     <= 1'b0;
    end else if (strb.loadEn) begin
      baseCol <= startCol;
      beatCnt <= '0;
      codeQ   <= lenCode;
      ilQ     <= interleave;
    end else if (strb.stepEn) begin
      beatCnt <= beatCnt + COL_W'(1);
    end
  end

  assign fullMode = (int'(codeQ) > MAX_LEN_LOG);
  assign sumCol   = baseCol + beatCnt;

  for (genvar i = 0; i < COL_W; i++) begin : g_bit
    assign mask[i] = fullMode || (i < int'(codeQ));
    assign col[i]  = !mask[i] ? baseCol[i] :
                     (ilQ && !fullMode) ? (baseCol[i] ^ beatCnt[i]) : sumCol[i];
  end

  assign atLast = !fullMode && (beatCnt == mask);

  assert_load_col_R2: assert property (@(posedge clk) disable iff (!rstN)
    strb.loadEn |=> (col == $past(startCol)) && (beatCnt == '0));
  assert_step_count_R3: assert property (@(posedge clk) disable iff (!rstN)
    strb.stepEn |=> beatCnt == $past(beatCnt) + COL_W'(1));
  assert_hold_col_R3: assert property (@(posedge clk) disable iff (!rstN)
    (!strb.stepEn && !strb.loadEn) |=> $stable(col));
  assert_full_nolast_R8: assert property (@(posedge clk) disable iff (!rstN)
    fullMode |-> !atLast);
  assert_full_step_R8: assert property (@(posedge clk) disable iff (!rstN)
    (strb.stepEn && fullMode) |=> col == $past(col) + COL_W'(1));

endmodule

// File: rtl/burst_col_gen.sv
module burst_col_gen
  import bcg_pkg::*;
#(
  parameter int COL_W       = 8,
  parameter int CODE_W      = 3,
  parameter int MAX_LEN_LOG = 3
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              load,
  input  logic [COL_W-1:0]  startCol,
  input  logic [CODE_W-1:0] lenCode,
  input  logic              interleave,
  input  logic              advance,
  input  logic              terminate,
  output logic [COL_W-1:0]  col,
  output logic              colValid,
  output logic              lastBeat
);

  bcg_strobe_t strb;
  logic        active;
  logic        atLast;
  logic        fullMode;

  bcg_ctrl u_ctrl (
    .clk(clk), .rstN(rstN), .load(load), .advance(advance),
    .terminate(terminate), .atLast(atLast), .strb(strb), .active(active)
  );

  bcg_dp #(.COL_W(COL_W), .CODE_W(CODE_W), .MAX_LEN_LOG(MAX_LEN_LOG)) u_dp (
    .clk(clk), .rstN(rstN), .strb(strb), .startCol(startCol),
    .lenCode(lenCode), .interleave(interleave), .col(col),
    .atLast(atLast), .fullMode(fullMode)
  );

  assign colValid = active;
  assign lastBeat = active && atLast;

  assert_reset_idle_R1: assert property (@(posedge clk) disable iff (!rstN)
    lastBeat |-> colValid);
  assert_full_nolast_top_R8: assert property (@(posedge clk) disable iff (!rstN)
    fullMode |-> !lastBeat);

endmodule

// File: tb/burst_col_gen_tb.sv
module burst_col_gen_tb;
  logic       clk = 1'b0;
  logic       rstN = 1'b0;
  logic       load = 1'b0;
  logic [7:0] startCol = '0;
  logic [2:0] lenCode = '0;
  logic       interleave = 1'b0;
  logic       advance = 1'b0;
  logic       terminate = 1'b0;
  logic [7:0] col;
  logic       colValid;
  logic       lastBeat;

  int nChecks = 0;
  int nFails = 0;
  bit done = 0;

  always #10 clk = ~clk;

  burst_col_gen u_dut (
    .clk(clk), .rstN(rstN), .load(load), .startCol(startCol),
    .lenCode(lenCode), .interleave(interleave), .advance(advance),
    .terminate(terminate), .col(col), .colValid(colValid), .lastBeat(lastBeat)
  );

  task automatic tick();
    @(posedge clk);
    @(negedge clk);
  endtask

  task automatic check(string req, int act, int exp);
    nChecks++;
    if (act != exp) begin
      nFails++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  function automatic logic [7:0] model(logic [7:0] s, int code, bit il, int beat);
    logic [7:0] m;
    logic [7:0] b;
    b = 8'(beat);
    if (code >= 4) return s + b;
    m = 8'((1 << code) - 1);
    if (il) return (s & ~m) | ((s ^ b) & m);
    return (s & ~m) | ((s + b) & m);
  endfunction

  task automatic startBurst(logic [7:0] s, int code, bit il);
    load = 1; startCol = s; lenCode = 3'(code); interleave = il;
    advance = 0; terminate = 0;
    tick();
    load = 0;
  endtask

  // R3 R4 R5 R6 R7: complete fixed burst with continuous advance
  task automatic runFixed(string req, logic [7:0] s, int code, bit il);
    int len;
    len = 1 << code;
    startBurst(s, code, il);
    for (int b = 0; b < len; b++) begin
      check({req, " col"}, col, model(s, code, il, b));
      check({req, " valid"}, colValid, 1);
      check({req, " R7 last"}, lastBeat, (b == len - 1) ? 1 : 0);
      advance = 1;
      tick();
    end
    advance = 0;
    check({req, " R7 end"}, colValid, 0);
  endtask

  task automatic testReset();
    check("R1 valid", colValid, 0);
    check("R1 last", lastBeat, 0);
  endtask

  task automatic testSequential();
    runFixed("R4 len2", 8'h37, 1, 0);
    runFixed("R4 len4", 8'hA6, 2, 0);
    runFixed("R4 len8", 8'h5D, 3, 0);
  endtask

  task automatic testInterleave();
    runFixed("R5 len2", 8'h11, 1, 1);
    runFixed("R5 len4", 8'h4B, 2, 1);
    runFixed("R5 len8", 8'hC5, 3, 1);
  endtask

  task automatic testLenOne();
    runFixed("R6 len1", 8'h9E, 0, 0);
    runFixed("R6 len1 il", 8'h03, 0, 1);
  endtask

  task automatic testGaps();
    startBurst(8'h2E, 3, 0);
    for (int b = 0; b < 8; b++) begin
      advance = 0;
      tick();
      check("R3 hold col", col, model(8'h2E, 3, 0, b));
      check("R3 hold valid", colValid, 1);
      advance = 1;
      tick();
    end
    advance = 0;
    check("R3 gaps end", colValid, 0);
  endtask

  task automatic testFullPage();
    startBurst(8'hF0, 7, 1);
    for (int b = 0; b < 300; b++) begin
      check("R8 col", col, model(8'hF0, 7, 1, b));
      check("R8 valid", colValid, 1);
      check("R8 last", lastBeat, 0);
      advance = 1;
      tick();
    end
    advance = 0;
    terminate = 1;
    tick();
    terminate = 0;
    check("R9 full term", colValid, 0);
    startBurst(8'h05, 4, 0);
    for (int b = 0; b < 20; b++) begin
      check("R8 code4 col", col, model(8'h05, 4, 0, b));
      advance = 1;
      tick();
    end
    advance = 0;
    check("R8 code4 valid", colValid, 1);
  endtask

  task automatic testTerminate();
    startBurst(8'h40, 3, 0);
    advance = 1;
    tick();
    tick();
    advance = 0;
    terminate = 1;
    tick();
    terminate = 0;
    check("R9 fixed term valid", colValid, 0);
    check("R9 fixed term last", lastBeat, 0);
  endtask

  task automatic testReload();
    startBurst(8'h10, 3, 0);
    advance = 1;
    tick();
    tick();
    tick();
    load = 1; startCol = 8'h7A; lenCode = 3'd2; interleave = 1;
    tick();
    load = 0;
    advance = 0;
    check("R2 reload col", col, 8'h7A);
    check("R2 reload valid", colValid, 1);
    check("R2 reload last", lastBeat, 0);
    load = 1; terminate = 1; startCol = 8'hB3; lenCode = 3'd1; interleave = 0;
    tick();
    load = 0; terminate = 0;
    check("R2 load over term valid", colValid, 1);
    check("R2 load over term col", col, 8'hB3);
    advance = 1;
    tick();
    check("R2 after reload col", col, 8'hB2);
    check("R7 after reload last", lastBeat, 1);
    tick();
    advance = 0;
    check("R7 after reload end", colValid, 0);
  endtask

  task automatic testIdle();
    advance = 1;
    tick();
    tick();
    terminate = 1;
    tick();
    advance = 0; terminate = 0;
    tick();
    check("R10 idle valid", colValid, 0);
    check("R10 idle last", lastBeat, 0);
    startBurst(8'h66, 2, 0);
    check("R10 restart col", col, 8'h66);
    check("R10 restart valid", colValid, 1);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      nChecks++;
      nFails++;
      $display("FAIL watchdog: actual %0d expected %0d", 0, 1);
      $display("  [TB] %0d tests run, %0d failed", nChecks, nFails);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    testReset();
    rstN = 1;
    tick();
    testReset();
    testSequential();
    testInterleave();
    testLenOne();
    testGaps();
    testFullPage();
    testTerminate();
    testReload();
    testIdle();
    done = 1;
    $display("  [TB] %0d tests run, %0d failed", nChecks, nFails);
    $finish;
  end
endmodule